// File: doc/BRIEF.md
# Ranked Power-Rail Enable Sequencer

This block owns the enable lines of fourteen regulator rails and switches them on in groups during power-up. Every rail carries a two-bit rank held in a small rank store, which takes its default contents at reset and can be rewritten one rail at a time. When the power-state controller pulses the start input, the sequencer turns on all rank-1 rails, waits a programmable settle interval, then turns on the rank-2 rails, and finally the rank-3 rails. A rank with no rails in it costs no time. Rank 0 means the automatic sequence leaves the rail alone.

Once the last populated rank is on, the block reports done and enters its active state. In that state, software can switch any rail on by writing an enable mask. A mask written while the sequence is still running is kept and takes effect at the moment done rises. A mask written while the block is off is dropped. A stop pulse from the power-state controller drops every enable at once and returns the block to off. Ranks are copied into a working set at start, so rewriting a rank during a sequence only affects the next sequence.

Top module: `rail_seq_top`

## Requirements
- R1: After reset, every rail enable and done are low, and the settle count is 8. Rail indices have these ranks: 0 core = 2, 2 I/O = 1, 3 general buck = 2, 7 USB LDO = 3, 8 analog LDO = 2. Rails 1, 4, 5, 6, 9, 10 (DDR, LDO1-3, LDO6, DDR reference) and 11, 12, 13 (boost, OTG bus, switch) have rank 0.
- R2: Counting the cycle after the clock edge that samples start as cycle 0, the lowest populated rank turns on in cycle 1. Populated ranks then follow in increasing order. Enabled rails stay on until stop.
- R3: With settle count D, each populated rank turns on D+1 cycles after the previous populated rank. D = 0 gives back-to-back ranks.
- R4: A rank with no rails is skipped and adds no cycles.
- R5: The automatic sequence never enables a rail of rank 0.
- R6: Done rises one cycle after the last populated rank turns on, or in cycle 2 if no rail has rank 1 to 3. It stays high until stop.
- R7: A rank write during a sequence does not change that sequence. It applies from the next start on.
- R8: While done is high, a software mask write sets the software enables from the next cycle. Each rail output is the OR of its automatic and software enables.
- R9: A software mask written while the sequence runs has no effect on the outputs until done rises. It appears in the same cycle as done.
- R10: A software mask written while the block is off is ignored, both at that time and after the next sequence.
- R11: A stop pulse clears all rail enables and done from the next cycle. Stop wins over a simultaneous start.
- R12: A start pulse while a sequence runs or while done is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin the power-up sequence (accepted only when off) |
| stop_i | input | 1 | Force every rail off and return to off |
| rank_we_i | input | 1 | Write one rail's rank |
| rank_idx_i | input | 4 | Rail index for the rank write |
| rank_val_i | input | 2 | New rank value |
| dly_we_i | input | 1 | Write the settle count |
| dly_val_i | input | 16 | New settle count in cycles |
| sw_we_i | input | 1 | Write the software enable mask |
| sw_mask_i | input | 14 | Software enable mask, bit n = rail n |
| rail_en_o | output | 14 | Rail enables, bit n = rail n |
| done_o | output | 1 | Sequence complete, block active |

## Verification
Most internal faults show up as a rail enable edge in the wrong cycle. A wrong working-rank copy or a wrong rank search changes the pattern seen one cycle after start. A settle counter that loads or ends one off moves every later rank by one cycle, and this is visible within D+1 cycles of the previous rank. A lost or early pending mask shows up exactly in the cycle done rises, or in the cycles just before it. A stop that fails to clear state shows up one cycle after the pulse. The bench therefore compares every output on every cycle against an arithmetic model of the enable times, over swept rank patterns and settle counts.

// File: rtl/rseq_pkg.sv
package rseq_pkg;

    typedef enum logic [1:0] {
        ST_OFF = 2'd0,
        ST_RUN = 2'd1,
        ST_FIN = 2'd2,
        ST_ON  = 2'd3
    } seq_state_e;

endpackage

// File: rtl/rseq_rank_bank.sv
module rseq_rank_bank #(
    parameter int N_RAILS = 14,
    parameter logic [2*N_RAILS-1:0] RANK_INIT = '0,
    localparam int IDX_W = $clog2(N_RAILS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en_i,
    input  logic [IDX_W-1:0]             wr_idx_i,
    input  logic [1:0]                   wr_rank_i,
    input  logic                         latch_i,
    output logic [3:0][N_RAILS-1:0]      grp_mask_o
);

    typedef struct packed {
        logic [N_RAILS-1:0][1:0] bank;
        logic [N_RAILS-1:0][1:0] work;
    } bank_t;

    bank_t q, d;

    always_comb begin
        d = q;
        // start copies the programmed ranks into the working set
        if (latch_i) begin
            d.work = q.bank;
        end
        if (wr_en_i && (32'(wr_idx_i) < N_RAILS)) begin
            d.bank[wr_idx_i] = wr_rank_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= {RANK_INIT, RANK_INIT};
        end else begin
            q <= d;
        end
    end

    // one membership mask per rank, decoded from the working set
    for (genvar rr = 0; rr < 4; rr++) begin : g_rank
        for (genvar ii = 0; ii < N_RAILS; ii++) begin : g_rail
            assign grp_mask_o[rr][ii] = (q.work[ii] == 2'(rr));
        end
    end

endmodule

// File: rtl/rseq_ctrl.sv
module rseq_ctrl
    import rseq_pkg::*;
#(
    parameter int N_RAILS = 14,
    parameter int DLY_W   = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic                      stop_i,
    input  logic [3:0][N_RAILS-1:0]   grp_mask_i,
    input  logic [DLY_W-1:0]          dly_i,
    output logic                      latch_o,
    output seq_state_e                state_o,
    output logic [N_RAILS-1:0]        auto_en_o
);

    typedef struct packed {
        seq_state_e          state;
        logic [1:0]          cur;
        logic [DLY_W-1:0]    cnt;
        logic [N_RAILS-1:0]  auto_en;
    } ctl_t;

    ctl_t q, d;

    logic [3:1] populated;
    logic [1:0] tgt;
    logic       tgt_ok;
    logic       later_ok;

    always_comb begin
        for (int r = 1; r < 4; r++) begin
            populated[r] = |grp_mask_i[r];
        end
    end

    // lowest populated rank at or above the current one, and whether any follows it
    always_comb begin
        tgt      = 2'd0;
        tgt_ok   = 1'b0;
        later_ok = 1'b0;
        for (int r = 3; r >= 1; r--) begin
            if ((2'(r) >= q.cur) && populated[r]) begin
                tgt    = 2'(r);
                tgt_ok = 1'b1;
            end
        end
        for (int r = 1; r < 4; r++) begin
            if ((2'(r) > tgt) && populated[r]) begin
                later_ok = 1'b1;
            end
        end
    end

    always_comb begin
        d       = q;
        latch_o = 1'b0;
        case (q.state)
            ST_OFF: begin
                if (start_i) begin
                    latch_o = 1'b1;
                    d.state = ST_RUN;
                    d.cur   = 2'd1;
                    d.cnt   = '0;
                end
            end
            ST_RUN: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - 1'b1;
                end else if (!tgt_ok) begin
                    d.state = ST_FIN;
                end else begin
                    d.auto_en = q.auto_en | grp_mask_i[tgt];
                    if (later_ok) begin
                        d.cur = tgt + 2'd1;
                        d.cnt = dly_i;
                    end else begin
                        d.state = ST_FIN;
                    end
                end
            end
            ST_FIN: begin
                d.state = ST_ON;
            end
            ST_ON: begin
                d.state = ST_ON;
            end
            default: begin
                d.state = ST_OFF;
            end
        endcase
        if (stop_i) begin
            latch_o   = 1'b0;
            d.state   = ST_OFF;
            d.cur     = 2'd1;
            d.cnt     = '0;
            d.auto_en = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_OFF, cur: 2'd1, cnt: '0, auto_en: '0};
        end else begin
            q <= d;
        end
    end

    assign state_o   = q.state;
    assign auto_en_o = q.auto_en;

    // R5: manual-only rails never come from the automatic path
    p_rank0_manual_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.auto_en & grp_mask_i[0]) == '0);

    // R2: once on, an automatic enable stays on until stop
    p_monotone_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_i |=> ((q.auto_en & $past(q.auto_en)) == $past(q.auto_en)));

    // R3: the settle counter only runs inside the sequence
    p_cnt_in_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cnt != '0) |-> (q.state == ST_RUN));

    // R11: nothing is enabled automatically while off
    p_off_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_OFF) |-> (q.auto_en == '0));

endmodule

// File: rtl/rseq_sw_ctl.sv
module rseq_sw_ctl
    import rseq_pkg::*;
#(
    parameter int N_RAILS = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  seq_state_e          state_i,
    input  logic                stop_i,
    input  logic                we_i,
    input  logic [N_RAILS-1:0]  mask_i,
    output logic [N_RAILS-1:0]  sw_en_o
);

    typedef struct packed {
        logic [N_RAILS-1:0] en;
        logic [N_RAILS-1:0] pend;
        logic               pend_v;
    } sw_t;

    sw_t q, d;

    always_comb begin
        d = q;
        case (state_i)
            ST_RUN: begin
                if (we_i) begin
                    d.pend   = mask_i;
                    d.pend_v = 1'b1;
                end
            end
            ST_FIN: begin
                // the held mask lands together with done
                if (we_i) begin
                    d.en = mask_i;
                end else if (q.pend_v) begin
                    d.en = q.pend;
                end
                d.pend_v = 1'b0;
            end
            ST_ON: begin
                if (we_i) begin
                    d.en = mask_i;
                end
            end
            default: begin
                d = q;
            end
        endcase
        if (stop_i) begin
            d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign sw_en_o = q.en;

    // R10: software enables exist only in the active state
    p_sw_only_active_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|q.en) |-> (state_i == ST_ON));

    // R9: a pending mask never survives into the active state
    p_pend_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_ON) |-> !q.pend_v);

endmodule

// File: rtl/rail_seq_top.sv
module rail_seq_top
    import rseq_pkg::*;
#(
    parameter int N_RAILS  = 14,
    parameter int DLY_W    = 16,
    parameter logic [DLY_W-1:0] DLY_INIT = 16'd8,
    parameter logic [2*N_RAILS-1:0] RANK_INIT = 28'h002C092,
    localparam int IDX_W = $clog2(N_RAILS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                stop_i,
    input  logic                rank_we_i,
    input  logic [IDX_W-1:0]    rank_idx_i,
    input  logic [1:0]          rank_val_i,
    input  logic                dly_we_i,
    input  logic [DLY_W-1:0]    dly_val_i,
    input  logic                sw_we_i,
    input  logic [N_RAILS-1:0]  sw_mask_i,
    output logic [N_RAILS-1:0]  rail_en_o,
    output logic                done_o
);

    logic [DLY_W-1:0]          dly_q, dly_d;
    logic [3:0][N_RAILS-1:0]   grp_mask;
    logic                      latch;
    seq_state_e                state;
    logic [N_RAILS-1:0]        auto_en;
    logic [N_RAILS-1:0]        sw_en;

    always_comb begin
        dly_d = dly_q;
        if (dly_we_i) begin
            dly_d = dly_val_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dly_q <= DLY_INIT;
        end else begin
            dly_q <= dly_d;
        end
    end

    rseq_rank_bank #(
        .N_RAILS   (N_RAILS),
        .RANK_INIT (RANK_INIT)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (rank_we_i),
        .wr_idx_i   (rank_idx_i),
        .wr_rank_i  (rank_val_i),
        .latch_i    (latch),
        .grp_mask_o (grp_mask)
    );

    rseq_ctrl #(
        .N_RAILS (N_RAILS),
        .DLY_W   (DLY_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .stop_i     (stop_i),
        .grp_mask_i (grp_mask),
        .dly_i      (dly_q),
        .latch_o    (latch),
        .state_o    (state),
        .auto_en_o  (auto_en)
    );

    rseq_sw_ctl #(
        .N_RAILS (N_RAILS)
    ) u_sw (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_i (state),
        .stop_i  (stop_i),
        .we_i    (sw_we_i),
        .mask_i  (sw_mask_i),
        .sw_en_o (sw_en)
    );

    assign rail_en_o = auto_en | sw_en;
    assign done_o    = (state == ST_ON);

    // R2: a later rank is on only when every earlier rank is fully on
    p_order_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|(auto_en & grp_mask[3])) |-> ((auto_en & grp_mask[2]) == grp_mask[2]));
    p_order_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|(auto_en & grp_mask[2])) |-> ((auto_en & grp_mask[1]) == grp_mask[1]));

    // R11: stop clears every output on the next cycle
    p_stop_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> ((rail_en_o == '0) && !done_o));

    // R6: done holds until stop
    p_done_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !stop_i) |=> done_o);

endmodule

// File: tb/sim_rail_seq_top.sv
`timescale 1ns/1ps
module sim_rail_seq_top;

    localparam int NR = 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          stop_i = 1'b0;
    logic          rank_we_i = 1'b0;
    logic [3:0]    rank_idx_i = '0;
    logic [1:0]    rank_val_i = '0;
    logic          dly_we_i = 1'b0;
    logic [15:0]   dly_val_i = '0;
    logic          sw_we_i = 1'b0;
    logic [NR-1:0] sw_mask_i = '0;
    logic [NR-1:0] rail_en_o;
    logic          done_o;

    int n_chk = 0;
    int n_err = 0;
    int dly = 8;
    logic [1:0] rk [NR];
    bit finished = 0;

    always #4 clk = ~clk;

    rail_seq_top u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .stop_i     (stop_i),
        .rank_we_i  (rank_we_i),
        .rank_idx_i (rank_idx_i),
        .rank_val_i (rank_val_i),
        .dly_we_i   (dly_we_i),
        .dly_val_i  (dly_val_i),
        .sw_we_i    (sw_we_i),
        .sw_mask_i  (sw_mask_i),
        .rail_en_o  (rail_en_o),
        .done_o     (done_o)
    );

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic write_rank(input int idx, input logic [1:0] val);
        @(negedge clk);
        rank_we_i = 1'b1; rank_idx_i = 4'(idx); rank_val_i = val;
        @(negedge clk);
        rank_we_i = 1'b0;
        rk[idx] = val;
    endtask

    task automatic set_dly(input int val);
        @(negedge clk);
        dly_we_i = 1'b1; dly_val_i = 16'(val);
        @(negedge clk);
        dly_we_i = 1'b0;
        dly = val;
    endtask

    task automatic auto_mask(output logic [NR-1:0] m);
        m = '0;
        for (int i = 0; i < NR; i++) if (rk[i] != 2'd0) m[i] = 1'b1;
    endtask

    task automatic do_stop(input string tag);
        @(negedge clk); stop_i = 1'b1;
        @(negedge clk); stop_i = 1'b0;
        chk(rail_en_o == '0, {tag, " R11 rails"}, 32'(rail_en_o), 0);
        chk(done_o == 1'b0, {tag, " R11 done"}, 32'(done_o), 0);
    endtask

    // model: populated ranks at cycles 1, 1+(D+1), ...; done one cycle after the last
    task automatic run_seq(input string tag, input bit rw, input int ridx, input logic [1:0] rval,
                           input bit sww, input logic [NR-1:0] swm);
        int tr [4];
        int t;
        int last;
        int tdone;
        logic [NR-1:0] exp;
        t = 1; last = -1; tr[0] = -1;
        for (int r = 1; r < 4; r++) begin
            bit any = 0;
            for (int i = 0; i < NR; i++) if (int'(rk[i]) == r) any = 1;
            if (any) begin tr[r] = t; last = t; t = t + dly + 1; end
            else tr[r] = -1;
        end
        tdone = (last < 0) ? 2 : last + 1;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        for (int n = 0; n <= tdone + 2; n++) begin
            if (n == 0) begin
                rank_we_i = rw; rank_idx_i = 4'(ridx); rank_val_i = rval;
                sw_we_i = sww; sw_mask_i = swm;
            end else begin
                rank_we_i = 1'b0; sw_we_i = 1'b0;
            end
            exp = '0;
            for (int i = 0; i < NR; i++)
                if (rk[i] != 2'd0 && tr[rk[i]] >= 0 && n >= tr[rk[i]]) exp[i] = 1'b1;
            if (sww && n >= tdone) exp = exp | swm;
            chk(rail_en_o == exp, {tag, " R2/R3/R4/R5/R9 rails"}, 32'(rail_en_o), 32'(exp));
            chk(done_o == (n >= tdone), {tag, " R6 done"}, 32'(done_o), 32'(n >= tdone));
            @(negedge clk);
        end
        rank_we_i = 1'b0; sw_we_i = 1'b0;
        if (rw) rk[ridx] = rval;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_err++; n_chk++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [NR-1:0] am;
        // R1 default ranks
        for (int i = 0; i < NR; i++) rk[i] = 2'd0;
        rk[0] = 2'd2; rk[2] = 2'd1; rk[3] = 2'd2; rk[7] = 2'd3; rk[8] = 2'd2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rail_en_o == '0, "R1 reset rails", 32'(rail_en_o), 0);
        chk(done_o == 1'b0, "R1 reset done", 32'(done_o), 0);

        run_seq("R1 defaults", 0, 0, 2'd0, 0, '0);

        // R8: software mask in active state
        auto_mask(am);
        @(negedge clk); sw_we_i = 1'b1; sw_mask_i = 14'h3C00;
        @(negedge clk); sw_we_i = 1'b0;
        chk(rail_en_o == (am | 14'h3C00), "R8 sw mask", 32'(rail_en_o), 32'(am | 14'h3C00));
        @(negedge clk); sw_we_i = 1'b1; sw_mask_i = 14'h0012;
        @(negedge clk); sw_we_i = 1'b0;
        chk(rail_en_o == (am | 14'h0012), "R8 sw rewrite", 32'(rail_en_o), 32'(am | 14'h0012));

        // R12: start while active
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        chk(rail_en_o == (am | 14'h0012), "R12 rails", 32'(rail_en_o), 32'(am | 14'h0012));
        chk(done_o == 1'b1, "R12 done", 32'(done_o), 1);
        @(negedge clk);
        chk(done_o == 1'b1, "R12 done later", 32'(done_o), 1);

        do_stop("after R8");

        // R10: software write while off
        @(negedge clk); sw_we_i = 1'b1; sw_mask_i = '1;
        @(negedge clk); sw_we_i = 1'b0;
        chk(rail_en_o == '0, "R10 off write", 32'(rail_en_o), 0);
        run_seq("R10 after", 0, 0, 2'd0, 0, '0);
        do_stop("after R10");

        // R7: rank rewrite mid-sequence
        run_seq("R7 old", 1, 1, 2'd1, 0, '0);
        do_stop("after R7 old");
        run_seq("R7 new", 0, 0, 2'd0, 0, '0);
        do_stop("after R7 new");

        // R9: software write during sequence
        run_seq("R9 held", 0, 0, 2'd0, 1, 14'h0402);
        do_stop("after R9");

        // R11: stop with start in the same cycle
        @(negedge clk); start_i = 1'b1; stop_i = 1'b1;
        @(negedge clk); start_i = 1'b0; stop_i = 1'b0;
        for (int n = 0; n < 3; n++) begin
            chk(rail_en_o == '0, "R11 stop beats start", 32'(rail_en_o), 0);
            chk(done_o == 1'b0, "R11 stop beats start done", 32'(done_o), 0);
            @(negedge clk);
        end

        // R11: stop in the middle of a sequence
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        repeat (3) @(negedge clk);
        do_stop("R11 mid");

        // R2 R3 R4 R5 R6 sweep over rank patterns and settle counts
        for (int p = 0; p < 16; p++) begin
            for (int di = 0; di < 3; di++) begin
                for (int i = 0; i < NR; i++) begin
                    logic [1:0] v;
                    if (p == 0) v = 2'd0;
                    else if (p == 1) v = 2'd3;
                    else v = 2'((i * (p + 1) + (p >> 1)) % 4);
                    write_rank(i, v);
                end
                set_dly((di == 0) ? 0 : (di == 1) ? 1 : 4);
                run_seq("sweep", 0, 0, 2'd0, 0, '0);
                do_stop("sweep");
            end
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule